// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs accesses on an external static-memory bus shared by several chip selects. An internal requester presents one access at a time: address, write data, direction and chip-select index. The controller then drives the external address, an active-low chip-select vector, an active-low write strobe, an active-low read strobe and a data-output enable. It signals completion with a one-bus-cycle done pulse, and for reads it also returns the captured data.

The controller is clocked at twice the bus rate. A phase input marks which half of the bus cycle each fast tick belongs to, so strobe edges can be placed with half-cycle resolution. Each chip select has its own settings: a wait-state enable, a 3-bit wait-state count and an early-read mode flag. A small write port loads these settings. Extra cycles are inserted when the target chip select differs from the previous one, and after writes in early-read mode.

Top module: `ebi_ws_ctrl`

Timing below is counted in ticks. A tick is half a bus cycle, which is one `clk2x` period. Tick 0 is the first tick after the accepting edge. `s` is 2 when a chip-select change cycle is inserted and 0 otherwise. `L` is the write-strobe low time in ticks.

## Requirements
- R1: A synchronous reset drives every chip-select line, `ebi_nwe` and `ebi_nre` high, with `ebi_doe` and `done` low. It also clears every chip select's settings to wait enable 0, count 0 and standard read, and sets the previous chip select to 0.
- R2: If a chip select's wait enable is 0, its accesses use zero wait states whatever its count field holds.
- R3: With zero effective wait states, `ebi_nwe` is low for exactly one tick (half a bus cycle).
- R4: With an effective count w from 1 to 7, `ebi_nwe` is low for exactly 2*w ticks, which is w bus cycles.
- R5: Exactly one chip-select line, the addressed one, is low from tick s to tick s+L+1, and `ebi_addr` carries the request address there. For writes, `ebi_nwe` is low from tick s+1 to tick s+L. This gives one tick of setup before the strobe falls and one tick of hold after it rises.
- R6: For a write, `ebi_doe` is high and `ebi_dout` carries the write data from tick s through tick s+L, and at no other time.
- R7: For a read in standard mode, `ebi_nre` is low from tick s+1 to tick s+L. `ebi_din` is sampled at the end of tick s+L and held on `rdata`. `ebi_nwe` and `ebi_nre` are never low together.
- R8: A chip select with early-read mode set lowers `ebi_nre` on reads from tick s, which is one tick earlier. On writes it appends one recovery bus cycle (2 ticks) with all lines inactive before the access ends.
- R9: If an access targets a different chip select from the previous accepted access, one idle bus cycle (ticks 0 and 1, all lines inactive) comes before the access, so s=2. Otherwise s=0.
- R10: An access lasts T = s + roundup_even(L+2) + (2 if an early-mode write) ticks. `done` is high in exactly ticks T-2 and T-1, which is its last bus cycle.
- R11: A request is accepted only at a rising edge where the controller is idle and `bus_ph` is 1 (the second half of a bus cycle). A request raised while an access is running is ignored.
- R12: A settings write changes only the chip select named by `cfg_sel`. The others keep their timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate clock, one tick per period |
| rst | input | 1 | Synchronous active-high reset |
| bus_ph | input | 1 | 0 in the first half, 1 in the second half of a bus cycle |
| cfg_we | input | 1 | Settings write strobe |
| cfg_sel | input | CSW | Chip select whose settings are written |
| cfg_wse | input | 1 | Wait-state enable to store |
| cfg_nws | input | 3 | Wait-state count to store |
| cfg_early | input | 1 | Early-read mode flag to store |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 for write, 0 for read |
| req_cs | input | CSW | Target chip-select index |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| done | output | 1 | High in the last bus cycle of an access |
| rdata | output | DW | Data captured by the most recent read |
| ebi_addr | output | AW | External address |
| ebi_ncs | output | NCS | Active-low chip selects |
| ebi_nwe | output | 1 | Active-low write strobe |
| ebi_nre | output | 1 | Active-low read strobe |
| ebi_dout | output | DW | Write data to the bus |
| ebi_doe | output | 1 | Data output enable |
| ebi_din | input | DW | Read data from the bus |

## Verification
The assertions assume that `bus_ph` alternates on every `clk2x` tick and starts at 0 after reset. The bench guarantees this by producing the phase from its own toggle flop, which is held in reset alongside the design. They also assume the settings and request fields are steady while a request is being offered. The bench changes these inputs only on falling edges and raises `req` only in a tick where it knows the phase is 1. It drops `req` one tick later, except for deliberate pokes during a running access that test that requests are ignored.

// File: rtl/ebi_ws_pkg.sv
package ebi_ws_pkg;

    localparam int NWS_W     = 3;
    localparam int MAX_NWS   = (1 << NWS_W) - 1;
    // change cycle + setup/strobe/hold rounded + recovery cycle
    localparam int MAX_TICKS = 2 + (2 * MAX_NWS + 2) + 2;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    typedef logic [CNT_W-1:0] tick_t;

    typedef struct packed {
        logic             wse;
        logic [NWS_W-1:0] nws;
        logic             early;
    } cs_cfg_t;

    // Tick positions of every pin event inside one access
    typedef struct packed {
        tick_t cs_first;
        tick_t wr_first;
        tick_t rd_first;
        tick_t strb_last;
        tick_t cs_last;
        tick_t done_first;
        tick_t last;
    } win_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    function automatic int strobe_ticks(cs_cfg_t c);
        int w;
        w = c.wse ? int'(c.nws) : 0;
        return (w == 0) ? 1 : 2 * w;
    endfunction

    function automatic win_t plan_window(cs_cfg_t c, logic we, logic cs_chg);
        win_t r;
        int   s;
        int   l;
        int   body;
        int   tot;
        s    = cs_chg ? 2 : 0;
        l    = strobe_ticks(c);
        body = l + 2;
        if ((body % 2) != 0) body = body + 1;
        tot  = s + body;
        if (we && c.early) tot = tot + 2;
        r.cs_first   = tick_t'(s);
        r.wr_first   = tick_t'(s + 1);
        r.rd_first   = c.early ? tick_t'(s) : tick_t'(s + 1);
        r.strb_last  = tick_t'(s + l);
        r.cs_last    = tick_t'(s + l + 1);
        r.done_first = tick_t'(tot - 2);
        r.last       = tick_t'(tot - 1);
        return r;
    endfunction

endpackage

// File: rtl/ebi_cfg_bank.sv
module ebi_cfg_bank
    import ebi_ws_pkg::*;
#(
    parameter int NCS = 4,
    parameter int CSW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [CSW-1:0] wr_sel,
    input  cs_cfg_t        wr_cfg,
    input  logic [CSW-1:0] rd_sel,
    output cs_cfg_t        rd_cfg
);

    cs_cfg_t bank [NCS];

    for (genvar g = 0; g < NCS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= '0;
            end else if (wr_en && (wr_sel == CSW'(g))) begin
                bank[g] <= wr_cfg;
            end
        end

        // R12
        slot_isolation_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_sel != CSW'(g)) |=> $stable(bank[g]));
    end

    always_comb begin
        rd_cfg = '0;
        for (int i = 0; i < NCS; i++) begin
            if (rd_sel == CSW'(i)) rd_cfg = bank[i];
        end
    end

endmodule

// File: rtl/ebi_seq.sv
module ebi_seq
    import ebi_ws_pkg::*;
#(
    parameter int CSW = 2,
    parameter int AW  = 16,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_ph,
    input  logic           req,
    input  logic           req_we,
    input  logic [CSW-1:0] req_cs,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  cs_cfg_t        sel_cfg,
    input  logic [DW-1:0]  ext_din,
    output logic           busy,
    output tick_t          cnt,
    output win_t           win,
    output logic           op_we,
    output logic [CSW-1:0] op_cs,
    output logic [AW-1:0]  op_addr,
    output logic [DW-1:0]  op_wdata,
    output logic [DW-1:0]  rdata
);

    seq_state_e     state;
    logic [CSW-1:0] prev_cs;
    logic           accept;

    assign accept = (state == SEQ_IDLE) && req && bus_ph;
    assign busy   = (state == SEQ_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            cnt      <= '0;
            win      <= '0;
            op_we    <= 1'b0;
            op_cs    <= '0;
            op_addr  <= '0;
            op_wdata <= '0;
            prev_cs  <= '0;
            rdata    <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        state    <= SEQ_RUN;
                        cnt      <= '0;
                        win      <= plan_window(sel_cfg, req_we, req_cs != prev_cs);
                        op_we    <= req_we;
                        op_cs    <= req_cs;
                        op_addr  <= req_addr;
                        op_wdata <= req_wdata;
                        prev_cs  <= req_cs;
                    end
                end
                SEQ_RUN: begin
                    if (!op_we && (cnt == win.strb_last)) rdata <= ext_din;
                    if (cnt == win.last) begin
                        state <= SEQ_IDLE;
                    end else begin
                        cnt <= cnt + tick_t'(1);
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R11
    start_on_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_ph));

    // R11
    op_held_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(op_cs) && $stable(op_addr) && $stable(op_we)));

endmodule

// File: rtl/ebi_pin_decode.sv
module ebi_pin_decode
    import ebi_ws_pkg::*;
#(
    parameter int NCS = 4,
    parameter int CSW = 2,
    parameter int AW  = 16,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           busy,
    input  tick_t          cnt,
    input  win_t           win,
    input  logic           op_we,
    input  logic [CSW-1:0] op_cs,
    input  logic [AW-1:0]  op_addr,
    input  logic [DW-1:0]  op_wdata,
    output logic [AW-1:0]  ebi_addr,
    output logic [NCS-1:0] ebi_ncs,
    output logic           ebi_nwe,
    output logic           ebi_nre,
    output logic [DW-1:0]  ebi_dout,
    output logic           ebi_doe,
    output logic           done
);

    logic cs_on;
    logic we_on;
    logic re_on;
    logic drv_on;

    always_comb begin
        cs_on  = busy && (cnt >= win.cs_first) && (cnt <= win.cs_last);
        we_on  = busy && op_we && (cnt >= win.wr_first) && (cnt <= win.strb_last);
        re_on  = busy && !op_we && (cnt >= win.rd_first) && (cnt <= win.strb_last);
        drv_on = busy && op_we && (cnt >= win.cs_first) && (cnt <= win.strb_last);
        done   = busy && (cnt >= win.done_first);
    end

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign ebi_ncs[g] = !(cs_on && (op_cs == CSW'(g)));
    end

    assign ebi_nwe  = !we_on;
    assign ebi_nre  = !re_on;
    assign ebi_doe  = drv_on;
    assign ebi_addr = cs_on ? op_addr : '0;
    assign ebi_dout = drv_on ? op_wdata : '0;

    // R5
    nwe_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ebi_nwe) |-> ($past(ebi_ncs) != '1));

    // R5
    nwe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ebi_nwe) |-> (ebi_ncs != '1));

    // R5
    single_cs_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ebi_ncs));

    // R6
    wdata_driven_chk: assert property (@(posedge clk) disable iff (rst)
        !ebi_nwe |-> ebi_doe);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (ebi_nwe || ebi_nre));

    // R10
    done_two_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |=> done);

    // R10
    done_ends_access_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> !busy);

endmodule

// File: rtl/ebi_ws_ctrl.sv
module ebi_ws_ctrl
    import ebi_ws_pkg::*;
#(
    parameter int NCS = 4,
    parameter int AW  = 16,
    parameter int DW  = 16,
    localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic             clk2x,
    input  logic             rst,
    input  logic             bus_ph,
    input  logic             cfg_we,
    input  logic [CSW-1:0]   cfg_sel,
    input  logic             cfg_wse,
    input  logic [NWS_W-1:0] cfg_nws,
    input  logic             cfg_early,
    input  logic             req,
    input  logic             req_we,
    input  logic [CSW-1:0]   req_cs,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             done,
    output logic [DW-1:0]    rdata,
    output logic [AW-1:0]    ebi_addr,
    output logic [NCS-1:0]   ebi_ncs,
    output logic             ebi_nwe,
    output logic             ebi_nre,
    output logic [DW-1:0]    ebi_dout,
    output logic             ebi_doe,
    input  logic [DW-1:0]    ebi_din
);

    cs_cfg_t        wr_cfg;
    cs_cfg_t        sel_cfg;
    logic           busy;
    tick_t          cnt;
    win_t           win;
    logic           op_we;
    logic [CSW-1:0] op_cs;
    logic [AW-1:0]  op_addr;
    logic [DW-1:0]  op_wdata;

    assign wr_cfg = '{wse: cfg_wse, nws: cfg_nws, early: cfg_early};

    ebi_cfg_bank #(.NCS(NCS), .CSW(CSW)) u_bank (
        .clk    (clk2x),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_sel (cfg_sel),
        .wr_cfg (wr_cfg),
        .rd_sel (req_cs),
        .rd_cfg (sel_cfg)
    );

    ebi_seq #(.CSW(CSW), .AW(AW), .DW(DW)) u_seq (
        .clk       (clk2x),
        .rst       (rst),
        .bus_ph    (bus_ph),
        .req       (req),
        .req_we    (req_we),
        .req_cs    (req_cs),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sel_cfg   (sel_cfg),
        .ext_din   (ebi_din),
        .busy      (busy),
        .cnt       (cnt),
        .win       (win),
        .op_we     (op_we),
        .op_cs     (op_cs),
        .op_addr   (op_addr),
        .op_wdata  (op_wdata),
        .rdata     (rdata)
    );

    ebi_pin_decode #(.NCS(NCS), .CSW(CSW), .AW(AW), .DW(DW)) u_pins (
        .clk      (clk2x),
        .rst      (rst),
        .busy     (busy),
        .cnt      (cnt),
        .win      (win),
        .op_we    (op_we),
        .op_cs    (op_cs),
        .op_addr  (op_addr),
        .op_wdata (op_wdata),
        .ebi_addr (ebi_addr),
        .ebi_ncs  (ebi_ncs),
        .ebi_nwe  (ebi_nwe),
        .ebi_nre  (ebi_nre),
        .ebi_dout (ebi_dout),
        .ebi_doe  (ebi_doe),
        .done     (done)
    );

endmodule

// File: tb/ebi_ws_ctrl_tb.sv
`timescale 1ns/1ps
module ebi_ws_ctrl_tb;

    localparam int NCS = 4;
    localparam int AW  = 16;
    localparam int DW  = 16;

    logic           clk2x = 1'b0;
    logic           rst;
    logic           ph;
    logic           cfg_we;
    logic [1:0]     cfg_sel;
    logic           cfg_wse;
    logic [2:0]     cfg_nws;
    logic           cfg_early;
    logic           req;
    logic           req_we;
    logic [1:0]     req_cs;
    logic [AW-1:0]  req_addr;
    logic [DW-1:0]  req_wdata;
    logic           done;
    logic [DW-1:0]  rdata;
    logic [AW-1:0]  ebi_addr;
    logic [NCS-1:0] ebi_ncs;
    logic           ebi_nwe;
    logic           ebi_nre;
    logic [DW-1:0]  ebi_dout;
    logic           ebi_doe;
    logic [DW-1:0]  ebi_din;

    int n_chk  = 0;
    int n_fail = 0;

    bit       m_wse   [NCS];
    int       m_nws   [NCS];
    bit       m_early [NCS];
    int       m_prev;
    int       last_low;
    int       last_len;

    always #2 clk2x = ~clk2x;

    always_ff @(posedge clk2x) begin
        if (rst) ph <= 1'b0;
        else     ph <= ~ph;
    end

    ebi_ws_ctrl #(.NCS(NCS), .AW(AW), .DW(DW)) u_dut (
        .clk2x     (clk2x),
        .rst       (rst),
        .bus_ph    (ph),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wse   (cfg_wse),
        .cfg_nws   (cfg_nws),
        .cfg_early (cfg_early),
        .req       (req),
        .req_we    (req_we),
        .req_cs    (req_cs),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .done      (done),
        .rdata     (rdata),
        .ebi_addr  (ebi_addr),
        .ebi_ncs   (ebi_ncs),
        .ebi_nwe   (ebi_nwe),
        .ebi_nre   (ebi_nre),
        .ebi_dout  (ebi_dout),
        .ebi_doe   (ebi_doe),
        .ebi_din   (ebi_din)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int eff_ws(int cs);
        return m_wse[cs] ? m_nws[cs] : 0;
    endfunction

    function automatic int low_ticks(int cs);
        return (eff_ws(cs) == 0) ? 1 : 2 * eff_ws(cs);
    endfunction

    function automatic string strobe_tag(int cs);
        if (!m_wse[cs] && m_nws[cs] != 0) return "R2";
        return (eff_ws(cs) == 0) ? "R3" : "R4";
    endfunction

    task automatic check_idle(input string tag);
        chk(ebi_ncs == 4'hF, tag, "idle ncs", int'(ebi_ncs), 15);
        chk(ebi_nwe && ebi_nre, tag, "idle strobes", int'({ebi_nwe, ebi_nre}), 3);
        chk(!ebi_doe && !done, tag, "idle doe/done", int'({ebi_doe, done}), 0);
    endtask

    task automatic write_cfg(input int cs, input bit wse, input int nws, input bit early);
        cfg_we    = 1'b1;
        cfg_sel   = 2'(cs);
        cfg_wse   = wse;
        cfg_nws   = 3'(nws);
        cfg_early = early;
        @(negedge clk2x);
        cfg_we    = 1'b0;
        m_wse[cs]   = wse;
        m_nws[cs]   = nws;
        m_early[cs] = early;
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic run_access(input int cs, input bit we, input int addr,
                              input int wdata, input int din, input bit poke);
        int    s, l, body, tot, rd0;
        bit    early;
        string stag;
        early = m_early[cs];
        s     = (cs != m_prev) ? 2 : 0;
        l     = low_ticks(cs);
        body  = l + 2;
        if ((body % 2) != 0) body++;
        tot   = s + body + ((we && early) ? 2 : 0);
        rd0   = early ? s : s + 1;
        stag  = strobe_tag(cs);
        ebi_din = DW'(din);
        while (ph !== 1'b1) @(negedge clk2x);
        req       = 1'b1;
        req_we    = we;
        req_cs    = 2'(cs);
        req_addr  = AW'(addr);
        req_wdata = DW'(wdata);
        @(negedge clk2x);
        req = 1'b0;
        last_low = 0;
        last_len = tot;
        for (int t = 0; t < tot; t++) begin
            bit   e_cs, e_we, e_re, e_doe, e_done;
            logic [NCS-1:0] e_ncs;
            e_cs   = (t >= s) && (t <= s + l + 1);
            e_we   = we && (t >= s + 1) && (t <= s + l);
            e_re   = !we && (t >= rd0) && (t <= s + l);
            e_doe  = we && (t >= s) && (t <= s + l);
            e_done = (t >= tot - 2);
            e_ncs  = '1;
            if (e_cs) e_ncs[cs] = 1'b0;
            if (!ebi_nwe) last_low++;
            chk(ebi_ncs == e_ncs, (t < s) ? "R9" : "R5", "ncs", int'(ebi_ncs), int'(e_ncs));
            chk(ebi_nwe == !e_we, stag, "nwe", int'(ebi_nwe), int'(!e_we));
            chk(ebi_nre == !e_re, early ? "R8" : "R7", "nre", int'(ebi_nre), int'(!e_re));
            chk(ebi_doe == e_doe, "R6", "doe", int'(ebi_doe), int'(e_doe));
            chk(done == e_done, (we && early) ? "R8" : "R10", "done", int'(done), int'(e_done));
            if (e_cs) chk(ebi_addr == AW'(addr), "R5", "addr", int'(ebi_addr), addr);
            if (e_doe) chk(ebi_dout == DW'(wdata), "R6", "dout", int'(ebi_dout), wdata);
            if (!we && t == tot - 1) chk(rdata == DW'(din), "R7", "rdata", int'(rdata), din);
            if (poke && t == 2) begin
                req    = 1'b1;
                req_cs = 2'((cs + 1) % NCS);
                req_we = ~we;
            end
            if (poke && t == 3) req = 1'b0;
            if (t < tot - 1) @(negedge clk2x);
        end
        m_prev = cs;
        @(negedge clk2x);
        check_idle(poke ? "R11" : "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk2x);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_wse = 0; cfg_nws = 0; cfg_early = 0;
        req = 0; req_we = 0; req_cs = 0; req_addr = 0; req_wdata = 0; ebi_din = 0;
        for (int i = 0; i < NCS; i++) begin
            m_wse[i] = 0; m_nws[i] = 0; m_early[i] = 0;
        end
        m_prev = 0;
        repeat (4) @(negedge clk2x);
        rst = 1'b0;
        // R1: reset state of the pins
        check_idle("R1");
        @(negedge clk2x);

        // R1: default settings give a zero-wait, same-select write on select 0
        run_access(0, 1'b1, 16'h1234, 16'hA5A5, 0, 1'b0);
        chk(last_low == 1, "R1", "default strobe ticks", last_low, 1);
        chk(last_len == 4, "R1", "default access ticks", last_len, 4);

        // R2: count programmed but enable clear
        write_cfg(1, 1'b0, 5, 1'b0);
        run_access(1, 1'b1, 16'h0040, 16'h5555, 0, 1'b0);
        chk(last_low == 1, "R2", "disabled wait ticks", last_low, 1);

        // R4: one and seven wait states
        write_cfg(1, 1'b1, 1, 1'b0);
        run_access(1, 1'b1, 16'h0041, 16'h1111, 0, 1'b0);
        chk(last_low == 2, "R4", "one wait ticks", last_low, 2);
        write_cfg(1, 1'b1, 7, 1'b0);
        run_access(1, 1'b1, 16'h0042, 16'h2222, 0, 1'b0);
        chk(last_low == 14, "R4", "seven wait ticks", last_low, 14);

        // R12: other select keeps its own setting
        write_cfg(2, 1'b1, 3, 1'b1);
        run_access(1, 1'b1, 16'h0043, 16'h3333, 0, 1'b0);
        chk(last_low == 14, "R12", "neighbour unchanged", last_low, 14);

        // R7 / R8: reads and early-mode write
        run_access(2, 1'b0, 16'h0100, 0, 16'hBEEF, 1'b0);
        run_access(2, 1'b1, 16'h0101, 16'hCAFE, 0, 1'b0);
        chk(last_len == 10, "R8", "early write length", last_len, 10);
        run_access(3, 1'b0, 16'h0200, 0, 16'h0F0F, 1'b0);

        // R11: poke a request while busy
        run_access(3, 1'b1, 16'h0300, 16'h7777, 0, 1'b1);
        repeat (3) begin
            @(negedge clk2x);
            check_idle("R11");
        end

        // Random mix
        for (int k = 0; k < 150; k++) begin
            if (($urandom % 4) == 0)
                write_cfg(int'($urandom % NCS), 1'($urandom), int'($urandom % 8), 1'($urandom));
            run_access(int'($urandom % NCS), 1'($urandom), int'($urandom % 65536),
                       int'($urandom % 65536), int'($urandom % 65536), (($urandom % 8) == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule